// File: doc/BRIEF.md
# Paired-channel conversion request sequencer

This block schedules a converter that always samples its analog inputs two at a time. Six input pairs each have a request line. The sequencer latches the requests and grants one pair at a time to a single conversion engine, lowest pair number first. It then runs the two conversions of that pair back to back. The engine is modelled inside the block as a counter that signals completion a fixed number of converter clocks after each start.

For every pair the block drives three outputs. A pending flag is set while the pair waits or converts. A ready flag is held until software clears it. An interrupt pulse is the third output. A mode input chooses when the ready flag and interrupt are raised: after the first conversion of the pair, or only after both. Interrupt masking and interrupt priority belong to the surrounding logic.

Top module: `pair_conv_seq`

## Requirements
- R1: While reset is held low, every pending, ready and interrupt output is 0 and `conv_busy_o` is 0.
- R2: When several pairs are pending and the engine is idle, the pair with the lowest index is granted. There is no rotation, and a lower pair that arrives while another pair converts is granted ahead of higher pairs that are already waiting.
- R3: When a set of pairs is requested in the same cycle, the pairs are converted one after another in ascending index order. Each grant comes 2*CONV_CLKS+1 cycles after the previous grant, and the first grant comes 2 cycles after the request cycle.
- R4: A pair's pending bit rises one cycle after its request is sampled. It stays high until its second conversion ends and falls 2*CONV_CLKS cycles after the grant, at the same edge where `conv_busy_o` falls.
- R5: With `early_irq_en`=1, the pair's ready bit and interrupt are set CONV_CLKS cycles after the grant, at the end of the first conversion. With `early_irq_en`=0 they are set 2*CONV_CLKS cycles after the grant.
- R6: A ready bit stays at 1 until its `rdy_clr_i` bit is high at a clock edge. If a set and a clear of the same bit meet at one edge, the bit becomes 1.
- R7: The sequencer never starts a conversion without a request. A request for a pair whose pending bit is already 1 is absorbed, and no second conversion of that pair follows.
- R8: `irq_o[p]` is high for exactly one cycle, in the first cycle that ready bit p is set by a conversion. It pulses even when the ready bit was already 1, and at most one interrupt bit is high at a time.
- R9: Each conversion lasts CONV_CLKS cycles. `conv_half_o` is 0 during the first conversion of the granted pair and 1 during the second, and `conv_pair_o` holds the granted pair index while `conv_busy_o` is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Converter clock |
| rst_n | input | 1 | Active-low synchronous reset |
| early_irq_en | input | 1 | 1: ready and interrupt after the first conversion of a pair |
| trig_i | input | NUM_PAIRS | Conversion request, one bit per pair |
| rdy_clr_i | input | NUM_PAIRS | Software clear of ready bits |
| conv_busy_o | output | 1 | Engine converting a granted pair |
| conv_pair_o | output | IDX_W | Index of the granted pair |
| conv_half_o | output | 1 | 0 first conversion, 1 second conversion |
| pend_o | output | NUM_PAIRS | Pending flags |
| rdy_o | output | NUM_PAIRS | Sticky ready flags |
| irq_o | output | NUM_PAIRS | Per-pair interrupt pulses |

## Verification
The assertions check four properties on every cycle. A grant always goes to the lowest pending pair. The active pair stays pending while it converts. Ready bits hold unless cleared, and interrupts are single pulses with at most one bit high, each matched by a set ready bit. A pending bit only rises after a request, so the sequencer cannot loop on its own. The bench scenarios show the exact cycle counts, which no single-cycle property can express. These are the placement of the ready flag in each mode, the spacing of grants across every subset of simultaneous requests, the set-wins collision with a clear, and the absorption of a repeated request.

// File: rtl/pcs_pkg.sv
package pcs_pkg;
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_FIRST  = 2'd1,
        ST_SECOND = 2'd2
    } seq_state_e;
endpackage

// File: rtl/pcs_arbiter.sv
module pcs_arbiter #(
    parameter int NUM_PAIRS = 6,
    localparam int IDX_W = (NUM_PAIRS > 1) ? $clog2(NUM_PAIRS) : 1
) (
    input  logic [NUM_PAIRS-1:0] req,
    output logic                 valid,
    output logic [IDX_W-1:0]     idx
);
    always_comb begin
        valid = 1'b0;
        idx   = '0;
        for (int i = NUM_PAIRS - 1; i >= 0; i--) begin
            if (req[i]) begin
                valid = 1'b1;
                idx   = IDX_W'(i);
            end
        end
    end
endmodule

// File: rtl/pcs_conv_model.sv
module pcs_conv_model #(
    parameter int CONV_CLKS = 12,
    localparam int CNT_W = $clog2(CONV_CLKS + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic done
);
    typedef struct packed {
        logic             active;
        logic [CNT_W-1:0] cnt;
    } model_t;

    model_t cur_q, cur_d;

    assign done = cur_q.active && (cur_q.cnt == '0);

    always_comb begin
        cur_d = cur_q;
        if (start) begin
            cur_d.active = 1'b1;
            cur_d.cnt    = CNT_W'(CONV_CLKS - 1);
        end else if (done) begin
            cur_d.active = 1'b0;
        end else if (cur_q.active) begin
            cur_d.cnt = cur_q.cnt - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cur_q <= '0;
        else        cur_q <= cur_d;
    end
endmodule

// File: rtl/pcs_engine_fsm.sv
module pcs_engine_fsm
    import pcs_pkg::*;
#(
    parameter int NUM_PAIRS = 6,
    localparam int IDX_W = (NUM_PAIRS > 1) ? $clog2(NUM_PAIRS) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             grant_valid,
    input  logic [IDX_W-1:0] grant_idx,
    input  logic             conv_done,
    output logic             conv_start,
    output logic             busy,
    output logic             half,
    output logic [IDX_W-1:0] pair,
    output logic             first_done,
    output logic             pair_done
);
    typedef struct packed {
        seq_state_e       st;
        logic [IDX_W-1:0] pair;
    } fsm_t;

    fsm_t cur_q, cur_d;

    assign busy       = (cur_q.st != ST_IDLE);
    assign half       = (cur_q.st == ST_SECOND);
    assign pair       = cur_q.pair;
    assign first_done = (cur_q.st == ST_FIRST) && conv_done;
    assign pair_done  = (cur_q.st == ST_SECOND) && conv_done;

    always_comb begin
        cur_d      = cur_q;
        conv_start = 1'b0;
        unique case (cur_q.st)
            ST_IDLE: begin
                if (grant_valid) begin
                    cur_d.st   = ST_FIRST;
                    cur_d.pair = grant_idx;
                    conv_start = 1'b1;
                end
            end
            ST_FIRST: begin
                if (conv_done) begin
                    cur_d.st   = ST_SECOND;
                    conv_start = 1'b1;
                end
            end
            ST_SECOND: begin
                if (conv_done) cur_d.st = ST_IDLE;
            end
            default: cur_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cur_q <= '{st: ST_IDLE, pair: '0};
        else        cur_q <= cur_d;
    end
endmodule

// File: rtl/pcs_flag_bank.sv
module pcs_flag_bank #(
    parameter int NUM_PAIRS = 6
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_PAIRS-1:0] trig,
    input  logic [NUM_PAIRS-1:0] pend_clr,
    input  logic [NUM_PAIRS-1:0] rdy_set,
    input  logic [NUM_PAIRS-1:0] rdy_clr,
    output logic [NUM_PAIRS-1:0] pend,
    output logic [NUM_PAIRS-1:0] rdy,
    output logic [NUM_PAIRS-1:0] irq
);
    for (genvar g = 0; g < NUM_PAIRS; g++) begin : g_pair
        typedef struct packed {
            logic pend;
            logic rdy;
            logic irq;
        } flag_t;

        flag_t cur_q, cur_d;

        always_comb begin
            cur_d = cur_q;
            if (pend_clr[g])   cur_d.pend = 1'b0;
            else if (trig[g])  cur_d.pend = 1'b1;
            cur_d.rdy = rdy_set[g] | (cur_q.rdy & ~rdy_clr[g]);
            cur_d.irq = rdy_set[g];
        end

        always_ff @(posedge clk) begin
            if (!rst_n) cur_q <= '0;
            else        cur_q <= cur_d;
        end

        assign pend[g] = cur_q.pend;
        assign rdy[g]  = cur_q.rdy;
        assign irq[g]  = cur_q.irq;
    end
endmodule

// File: rtl/pair_conv_seq.sv
module pair_conv_seq #(
    parameter int NUM_PAIRS = 6,
    parameter int CONV_CLKS = 12,
    localparam int IDX_W = (NUM_PAIRS > 1) ? $clog2(NUM_PAIRS) : 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 early_irq_en,
    input  logic [NUM_PAIRS-1:0] trig_i,
    input  logic [NUM_PAIRS-1:0] rdy_clr_i,
    output logic                 conv_busy_o,
    output logic [IDX_W-1:0]     conv_pair_o,
    output logic                 conv_half_o,
    output logic [NUM_PAIRS-1:0] pend_o,
    output logic [NUM_PAIRS-1:0] rdy_o,
    output logic [NUM_PAIRS-1:0] irq_o
);
    logic                 grant_valid;
    logic [IDX_W-1:0]     grant_idx;
    logic                 conv_start, conv_done;
    logic                 first_done, pair_done;
    logic [NUM_PAIRS-1:0] pair_sel, pend_clr, rdy_set;

    pcs_arbiter #(.NUM_PAIRS(NUM_PAIRS)) u_arb (
        .req   (pend_o),
        .valid (grant_valid),
        .idx   (grant_idx)
    );

    pcs_conv_model #(.CONV_CLKS(CONV_CLKS)) u_conv (
        .clk   (clk),
        .rst_n (rst_n),
        .start (conv_start),
        .done  (conv_done)
    );

    pcs_engine_fsm #(.NUM_PAIRS(NUM_PAIRS)) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .grant_valid (grant_valid),
        .grant_idx   (grant_idx),
        .conv_done   (conv_done),
        .conv_start  (conv_start),
        .busy        (conv_busy_o),
        .half        (conv_half_o),
        .pair        (conv_pair_o),
        .first_done  (first_done),
        .pair_done   (pair_done)
    );

    always_comb begin
        pair_sel = NUM_PAIRS'(1) << conv_pair_o;
        pend_clr = pair_done ? pair_sel : '0;
        rdy_set  = (early_irq_en ? first_done : pair_done) ? pair_sel : '0;
    end

    pcs_flag_bank #(.NUM_PAIRS(NUM_PAIRS)) u_flags (
        .clk      (clk),
        .rst_n    (rst_n),
        .trig     (trig_i),
        .pend_clr (pend_clr),
        .rdy_set  (rdy_set),
        .rdy_clr  (rdy_clr_i),
        .pend     (pend_o),
        .rdy      (rdy_o),
        .irq      (irq_o)
    );
endmodule

// File: rtl/pair_conv_seq_chk.sv
module pair_conv_seq_chk #(
    parameter int NUM_PAIRS = 6,
    parameter int CONV_CLKS = 12,
    localparam int IDX_W = (NUM_PAIRS > 1) ? $clog2(NUM_PAIRS) : 1
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic [NUM_PAIRS-1:0] trig_i,
    input logic [NUM_PAIRS-1:0] rdy_clr_i,
    input logic                 conv_busy_o,
    input logic [IDX_W-1:0]     conv_pair_o,
    input logic [NUM_PAIRS-1:0] pend_o,
    input logic [NUM_PAIRS-1:0] rdy_o,
    input logic [NUM_PAIRS-1:0] irq_o
);
    logic [IDX_W-1:0] lowest_pend;
    always_comb begin
        lowest_pend = '0;
        for (int i = NUM_PAIRS - 1; i >= 0; i--)
            if (pend_o[i]) lowest_pend = IDX_W'(i);
    end

    // R2
    grant_lowest_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(conv_busy_o) |-> conv_pair_o == $past(lowest_pend));

    // R4
    active_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
        conv_busy_o |-> pend_o[conv_pair_o]);

    // R8
    irq_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(irq_o));

    for (genvar g = 0; g < NUM_PAIRS; g++) begin : g_chk
        // R6
        rdy_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (rdy_o[g] && !rdy_clr_i[g]) |=> rdy_o[g]);
        // R8
        irq_with_rdy_chk: assert property (@(posedge clk) disable iff (!rst_n)
            irq_o[g] |-> rdy_o[g]);
        // R8
        irq_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
            irq_o[g] |=> !irq_o[g]);
        // R7
        no_self_loop_chk: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(pend_o[g]) |-> $past(trig_i[g]));
    end
endmodule

bind pair_conv_seq pair_conv_seq_chk #(
    .NUM_PAIRS (NUM_PAIRS),
    .CONV_CLKS (CONV_CLKS)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .trig_i      (trig_i),
    .rdy_clr_i   (rdy_clr_i),
    .conv_busy_o (conv_busy_o),
    .conv_pair_o (conv_pair_o),
    .pend_o      (pend_o),
    .rdy_o       (rdy_o),
    .irq_o       (irq_o)
);

// File: tb/sim_pair_conv_seq.sv
module sim_pair_conv_seq;
    localparam int CLK_PERIOD = 10;
    localparam int NP  = 6;
    localparam int N   = 12;
    localparam int PER = 2 * N + 1;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          early_irq_en = 1'b0;
    logic [NP-1:0] trig_i = '0;
    logic [NP-1:0] rdy_clr_i = '0;
    logic          conv_busy_o;
    logic [2:0]    conv_pair_o;
    logic          conv_half_o;
    logic [NP-1:0] pend_o, rdy_o, irq_o;

    int checks = 0;
    int errors = 0;

    pair_conv_seq #(.NUM_PAIRS(NP), .CONV_CLKS(N)) u0 (
        .clk(clk), .rst_n(rst_n), .early_irq_en(early_irq_en),
        .trig_i(trig_i), .rdy_clr_i(rdy_clr_i),
        .conv_busy_o(conv_busy_o), .conv_pair_o(conv_pair_o),
        .conv_half_o(conv_half_o), .pend_o(pend_o), .rdy_o(rdy_o),
        .irq_o(irq_o)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic expect_eq(input string req, input int act, input int exp);
        chk(act == exp, req, act, exp);
    endtask

    task automatic clear_all();
        @(negedge clk);
        rdy_clr_i = '1;
        @(negedge clk);
        rdy_clr_i = '0;
        expect_eq("R6 clear", int'(rdy_o), 0);
    endtask

    // R4 R5 R8 R9: one pair alone, cycle by cycle
    task automatic single_run(input int p, input bit early);
        early_irq_en = early;
        @(negedge clk);
        trig_i = NP'(1) << p;
        for (int k = 0; k <= PER + 1; k++) begin
            int  set_k;
            bit  e_busy, e_pend, e_rdy, e_irq;
            @(negedge clk);
            if (k == 0) trig_i = '0;
            set_k  = early ? (1 + N) : (1 + 2 * N);
            e_busy = (k >= 1) && (k <= 2 * N);
            e_pend = (k <= 2 * N);
            e_rdy  = (k >= set_k);
            e_irq  = (k == set_k);
            expect_eq("R4 pend", int'(pend_o[p]), int'(e_pend));
            expect_eq("R9 busy", int'(conv_busy_o), int'(e_busy));
            expect_eq("R5 rdy", int'(rdy_o[p]), int'(e_rdy));
            expect_eq("R8 irq", int'(irq_o[p]), int'(e_irq));
            if (e_busy) begin
                expect_eq("R9 pair", int'(conv_pair_o), p);
                expect_eq("R9 half", int'(conv_half_o), int'(k >= 1 + N));
            end
        end
    endtask

    // R3: a set of pairs requested together
    task automatic group_run(input int mask, input bit early);
        int order[NP];
        int n = 0;
        for (int i = 0; i < NP; i++)
            if (mask[i]) begin order[n] = i; n++; end
        early_irq_en = early;
        @(negedge clk);
        trig_i = NP'(mask);
        for (int k = 0; k <= n * PER; k++) begin
            @(negedge clk);
            if (k == 0) trig_i = '0;
            for (int j = 0; j < n; j++) begin
                if (k == 1 + j * PER) begin
                    expect_eq("R3 grant busy", int'(conv_busy_o), 1);
                    expect_eq("R3 grant pair", int'(conv_pair_o), order[j]);
                end
                if (j > 0 && k == j * PER)
                    expect_eq("R3 gap", int'(conv_busy_o), 0);
            end
        end
        expect_eq("R3 all done", int'(pend_o), 0);
        expect_eq("R3 ready set", int'(rdy_o), mask);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        expect_eq("R1 pend", int'(pend_o), 0);
        expect_eq("R1 rdy", int'(rdy_o), 0);
        expect_eq("R1 irq", int'(irq_o), 0);
        expect_eq("R1 busy", int'(conv_busy_o), 0);
        rst_n = 1'b1;

        for (int p = 0; p < NP; p++)
            for (int e = 0; e < 2; e++) begin
                single_run(p, e[0]);
                clear_all();
            end

        for (int m = 1; m < (1 << NP); m++) begin
            group_run(m, m[0] ^ m[3]);
            repeat (4) @(negedge clk);
            expect_eq("R6 sticky", int'(rdy_o), m);
            clear_all();
        end

        // R2: later lower pair overtakes a waiting higher pair
        early_irq_en = 1'b1;
        @(negedge clk);
        trig_i = 6'b001000;
        for (int k = 0; k <= 3 * PER; k++) begin
            @(negedge clk);
            trig_i = (k == 3) ? 6'b100000 : (k == 5) ? 6'b000010 : '0;
            if (k == 1)
                expect_eq("R2 first", int'(conv_pair_o), 3);
            if (k == PER + 1)
                expect_eq("R2 lower wins", int'(conv_pair_o), 1);
            if (k == 2 * PER + 1)
                expect_eq("R2 last", int'(conv_pair_o), 5);
        end
        expect_eq("R2 drained", int'(pend_o), 0);
        clear_all();

        // R6: set and clear meet at one edge, set wins
        early_irq_en = 1'b0;
        @(negedge clk);
        trig_i = 6'b000100;
        rdy_clr_i = 6'b000100;
        for (int k = 0; k <= PER + 1; k++) begin
            @(negedge clk);
            trig_i = '0;
            if (k == 2 * N)     expect_eq("R6 before", int'(rdy_o[2]), 0);
            if (k == 2 * N + 1) expect_eq("R6 set wins", int'(rdy_o[2]), 1);
            if (k == 2 * N + 2) expect_eq("R6 clear after", int'(rdy_o[2]), 0);
        end
        rdy_clr_i = '0;

        // R7: repeated request is absorbed, no self-restart
        @(negedge clk);
        trig_i = 6'b010000;
        begin
            int busy_cycles = 0;
            for (int k = 0; k <= 3 * PER; k++) begin
                @(negedge clk);
                trig_i = (k == 5) ? 6'b010000 : '0;
                if (conv_busy_o) busy_cycles++;
            end
            expect_eq("R7 one conversion", busy_cycles, 2 * N);
            expect_eq("R7 idle", int'(conv_busy_o), 0);
            expect_eq("R7 pend", int'(pend_o), 0);
        end

        // R8: interrupt pulses again while ready is still set
        expect_eq("R8 rdy held", int'(rdy_o[4]), 1);
        @(negedge clk);
        trig_i = 6'b010000;
        for (int k = 0; k <= PER; k++) begin
            @(negedge clk);
            trig_i = '0;
            if (k == 2 * N + 1) expect_eq("R8 re-pulse", int'(irq_o), 6'b010000);
            if (k == 2 * N)     expect_eq("R8 before pulse", int'(irq_o), 0);
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 150000);
        errors++;
        checks++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule